// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block is a clocked controller that performs write cycles on a 32K x 8 asynchronous static RAM, with write enable as the strobe that bounds each write. A client presents an address and a data byte with a level request. The controller latches both, asserts chip enable, waits out the address setup, then pulses write enable. It drives the data bus only inside a window that leaves the memory time to release its own outputs, and it keeps both the address and the data steady through a hold period after write enable rises. Then it releases chip enable and returns a one-cycle acknowledge.

Every duration is a parameter counted in clock cycles: address setup, write pulse width, bus turnaround, data setup and hold. Output enable stays high throughout, so the memory never drives the bus during a write. The turnaround delay covers the case where a read was in progress just before. If the client keeps the request high after the acknowledge, the next write follows with chip enable high for a fixed two-cycle gap.

Top module: `sram_write_seq`

## Requirements
- R1: While reset is held and right after it, memCeN, memWeN and memOeN are 1, memDqOe is 0 and wrAck is 0.
- R2: A request is taken only when the controller is idle, with both enables high. Address and data are captured on that clock edge, and later changes on wrAddr or wrData have no effect on the write in progress.
- R3: After memCeN falls, memWeN stays high for exactly SETUP_CYC cycles before it falls.
- R4: memWeN is low for exactly PW_CYC = max(PULSE_CYC, TURN_CYC + DSETUP_CYC) consecutive cycles, and memCeN is low during all of them.
- R5: memDqOe rises exactly TURN_CYC cycles after memWeN falls. It stays high until memCeN rises and is 0 at all other times, so it is high in the cycle in which memWeN rises.
- R6: Whenever memDqOe is 1, memDq carries the captured data byte (bit i of wrData on memDq bit i). It therefore holds that value for at least DSETUP_CYC cycles before memWeN rises.
- R7: memAddr equals the captured address and does not change while memCeN is low, which includes the hold period after memWeN rises.
- R8: memCeN rises exactly HOLD_CYC cycles after memWeN rises. memWeN is never low while memCeN is high.
- R9: wrAck is 1 for exactly one cycle: the first cycle in which memCeN is high again after a write.
- R10: memOeN is 1 at all times.
- R11: If the request is still asserted in the acknowledge cycle, memCeN stays high for exactly 2 cycles between the two writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrReq | input | 1 | Write request, held high until wrAck |
| wrAddr | input | 15 | Write address |
| wrData | input | 8 | Write data byte |
| wrAck | output | 1 | One-cycle completion pulse |
| memAddr | output | 15 | Memory address pins |
| memCeN | output | 1 | Chip enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memDq | inout | 8 | Memory data bus, tri-stated when not driven |
| memDqOe | output | 1 | High while the controller drives memDq |

## Verification
The assertions assume that the client holds wrReq high until wrAck arrives and that nothing else drives memDq, because the bus checks read memDq as the value the controller puts on it. The stimulus follows the request handshake. It changes wrAddr and wrData only at falling edges, and it scrambles them in the middle of a write only to show that they are ignored. The bench never drives memDq. It covers isolated writes separated by idle cycles and chains of back-to-back writes in which the request stays high.

// File: rtl/sramw_pkg.sv
package sramw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_DONE
  } wrState_t;

  typedef struct packed {
    logic load;    // capture request address and data
    logic ceOn;    // chip enable asserted
    logic weOn;    // write enable asserted
    logic drive;   // controller owns the data bus
    logic ack;     // completion pulse
  } wrStrobe_t;
endpackage

// File: rtl/sramw_ctrl.sv
module sramw_ctrl
  import sramw_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 3,
  parameter int TURN_CYC   = 1,
  parameter int DSETUP_CYC = 1,
  parameter int HOLD_CYC   = 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrReq,
  output wrStrobe_t strobe
);
  localparam int PW_CYC = (PULSE_CYC > TURN_CYC + DSETUP_CYC) ? PULSE_CYC : TURN_CYC + DSETUP_CYC;
  localparam int MAX_A  = (SETUP_CYC > PW_CYC) ? SETUP_CYC : PW_CYC;
  localparam int MAX_C  = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  wrState_t   state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (wrReq) state <= ST_SETUP;
        end
        ST_SETUP: begin
          if (cnt == CNT_W'(SETUP_CYC - 1)) begin
            cnt   <= '0;
            state <= ST_PULSE;
          end else cnt <= cnt + 1'b1;
        end
        ST_PULSE: begin
          if (cnt == CNT_W'(PW_CYC - 1)) begin
            cnt   <= '0;
            state <= ST_HOLD;
          end else cnt <= cnt + 1'b1;
        end
        ST_HOLD: begin
          if (cnt == CNT_W'(HOLD_CYC - 1)) begin
            cnt   <= '0;
            state <= ST_DONE;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          cnt   <= '0;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    strobe       = '0;
    strobe.load  = (state == ST_IDLE) && wrReq;
    strobe.ceOn  = (state == ST_SETUP) || (state == ST_PULSE) || (state == ST_HOLD);
    strobe.weOn  = (state == ST_PULSE);
    strobe.drive = ((state == ST_PULSE) && (cnt >= CNT_W'(TURN_CYC))) || (state == ST_HOLD);
    strobe.ack   = (state == ST_DONE);
  end

  // R2
  load_from_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (state == ST_SETUP));

  // R4
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PULSE) |-> (cnt < CNT_W'(PW_CYC)));
endmodule

// File: rtl/sramw_datapath.sv
module sramw_datapath
  import sramw_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrAck,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  inout  wire  [DATA_W-1:0] memDq,
  output logic              memDqOe
);
  logic [DATA_W-1:0] dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
      dataReg <= '0;
    end else if (strobe.load) begin
      memAddr <= wrAddr;
      dataReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCeN  <= 1'b1;
      memWeN  <= 1'b1;
      memDqOe <= 1'b0;
      wrAck   <= 1'b0;
    end else begin
      memCeN  <= ~strobe.ceOn;
      memWeN  <= ~strobe.weOn;
      memDqOe <= strobe.drive;
      wrAck   <= strobe.ack;
    end
  end

  assign memOeN = 1'b1;
  assign memDq  = memDqOe ? dataReg : {DATA_W{1'bz}};

  // R8
  we_inside_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !memCeN);

  // R7
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  // R5
  drive_at_we_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> memDqOe);

  // R5
  drive_inside_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> !memCeN);

  // R9
  ack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrAck |=> !wrAck);
endmodule

// File: rtl/sram_write_seq.sv
module sram_write_seq
  import sramw_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 3,
  parameter int TURN_CYC   = 1,
  parameter int DSETUP_CYC = 1,
  parameter int HOLD_CYC   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrReq,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrAck,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  inout  wire  [DATA_W-1:0] memDq,
  output logic              memDqOe
);
  wrStrobe_t strobe;

  sramw_ctrl #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .TURN_CYC  (TURN_CYC),
    .DSETUP_CYC(DSETUP_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrReq (wrReq),
    .strobe(strobe)
  );

  sramw_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .wrAck  (wrAck),
    .memAddr(memAddr),
    .memCeN (memCeN),
    .memWeN (memWeN),
    .memOeN (memOeN),
    .memDq  (memDq),
    .memDqOe(memDqOe)
  );
endmodule

// File: tb/test_sram_write_seq.sv
module test_sram_write_seq;
  localparam int SETUP_CYC = 2, PULSE_CYC = 3, TURN_CYC = 1, DSETUP_CYC = 1, HOLD_CYC = 1;
  localparam int PW_CYC = (PULSE_CYC > TURN_CYC + DSETUP_CYC) ? PULSE_CYC : TURN_CYC + DSETUP_CYC;

  logic clk = 1'b0, rstN = 1'b0, wrReq = 1'b0;
  logic [14:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic wrAck, memCeN, memWeN, memOeN, memDqOe;
  logic [14:0] memAddr;
  wire  [7:0]  memDq;

  int errors = 0, checks = 0;
  logic [22:0] expQ[$];
  logic [22:0] cur;
  bit   haveCur = 0, b2bPending = 0, running = 0, ackNext = 0;
  int   setupN = 0, pulseN = 0, turnN = -1, holdN = 0, gapN = 0;
  logic prevCe = 1'b1, prevWe = 1'b1;

  always #2.5 clk = ~clk;

  sram_write_seq i_sram_write_seq (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData),
    .wrAck(wrAck), .memAddr(memAddr), .memCeN(memCeN), .memWeN(memWeN),
    .memOeN(memOeN), .memDq(memDq), .memDqOe(memDqOe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: follows the pin sequence and pops the scoreboard at each write end
  always @(negedge clk) if (running) begin
    if (memOeN !== 1'b1) chk(0, "R10 oe held high", memOeN, 1);
    if (ackNext) begin
      chk(wrAck == 1'b0, "R9 ack lasts one cycle", wrAck, 0);
      ackNext = 0;
    end
    if (prevCe && !memCeN) begin
      if (b2bPending) begin
        chk(gapN == 2, "R11 back-to-back ce gap", gapN, 2);
        b2bPending = 0;
      end
      setupN = 0; pulseN = 0; turnN = -1; holdN = 0;
      chk(expQ.size() > 0, "R2 write without request", expQ.size(), 1);
      if (expQ.size() > 0) begin cur = expQ.pop_front(); haveCur = 1; end
    end
    if (memCeN) gapN++; else gapN = 0;
    if (!memCeN && memWeN && prevWe && pulseN == 0) setupN++;
    if (!memWeN) begin
      pulseN++;
      if (memDqOe && turnN < 0) turnN = pulseN - 1;
    end
    if (!memWeN && memCeN) chk(0, "R8 we low outside ce", 1, 0);
    if (haveCur && !memCeN && memAddr != cur[22:8])
      chk(0, "R7 address during ce", memAddr, cur[22:8]);
    if (haveCur && memDqOe && memDq != cur[7:0])
      chk(0, "R6 bus data", memDq, cur[7:0]);
    if (!prevWe && memWeN) begin
      chk(setupN == SETUP_CYC, "R3 address setup cycles", setupN, SETUP_CYC);
      chk(pulseN == PW_CYC, "R4 write pulse cycles", pulseN, PW_CYC);
      chk(turnN == TURN_CYC, "R5 turnaround cycles", turnN, TURN_CYC);
      chk(memDqOe == 1'b1, "R5 driven at we rise", memDqOe, 1);
      chk(memDq == cur[7:0], "R6 data at we rise", memDq, cur[7:0]);
      chk(memAddr == cur[22:8], "R7 address at we rise", memAddr, cur[22:8]);
    end
    if (memWeN && !memCeN && pulseN > 0) begin
      holdN++;
      chk(memDqOe == 1'b1, "R5 driven in hold", memDqOe, 1);
    end
    if (!prevCe || memCeN) begin
      if (!memCeN && memDqOe == 1'b0 && pulseN > 0 && memWeN)
        chk(0, "R5 bus released early", 0, 1);
    end
    if (!prevCe && memCeN) begin
      chk(holdN == HOLD_CYC, "R8 hold cycles", holdN, HOLD_CYC);
      chk(memDqOe == 1'b0, "R5 bus released with ce", memDqOe, 0);
      chk(wrAck == 1'b1, "R9 ack with ce rise", wrAck, 1);
      ackNext = 1;
      haveCur = 0;
    end else if (wrAck) chk(0, "R9 ack outside ce rise", 1, 0);
    if (memCeN && memDqOe) chk(0, "R5 driven outside ce", 1, 0);
    prevCe = memCeN;
    prevWe = memWeN;
  end

  // driver: one write, scrambling inputs mid-write, optionally keeping the request
  task automatic doWrite(input logic [14:0] a, input logic [7:0] d, input bit keep);
    if (!wrReq) @(negedge clk);
    wrAddr = a; wrData = d; wrReq = 1'b1;
    expQ.push_back({a, d});
    repeat (3) @(negedge clk);
    wrAddr = ~a; wrData = ~d;  // R2: must not reach the pins
    do @(negedge clk); while (!wrAck);
    if (keep) b2bPending = 1;
    else wrReq = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [22:0] lfsr;
    lfsr = 23'h5A3C1;
    repeat (3) @(negedge clk);
    chk(memCeN && memWeN && memOeN, "R1 strobes high in reset", {memCeN, memWeN, memOeN}, 7);
    chk(!memDqOe && !wrAck, "R1 bus off and no ack in reset", {memDqOe, wrAck}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(memCeN && memWeN && !memDqOe && !wrAck, "R1 state after reset",
        {memCeN, memWeN, memDqOe, wrAck}, 12);
    running = 1;
    prevCe = memCeN; prevWe = memWeN;
    doWrite(15'h0000, 8'h00, 0);
    repeat (4) @(negedge clk);
    doWrite(15'h7FFF, 8'hFF, 0);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      lfsr = {lfsr[21:0], lfsr[22] ^ lfsr[17]};
      doWrite(lfsr[22:8], lfsr[7:0], i < 5);
    end
    repeat (3) @(negedge clk);
    doWrite(15'h2AAA, 8'h55, 1);
    doWrite(15'h5555, 8'hAA, 0);
    repeat (5) @(negedge clk);
    chk(expQ.size() == 0, "R2 every request written once", expQ.size(), 0);
    chk(memCeN && memWeN && !memDqOe, "R1 idle after writes", {memCeN, memWeN, memDqOe}, 6);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule